// File: doc/BRIEF.md
# Masked Token-Arbitrated Hit Collector

This block gathers discriminated hits from a bank of 128 strip channels and turns them into a zero-suppressed stream of 20-bit words for a downstream FIFO. A beam-clock strobe marks each crossing. Every fourth strobe opens a capture. On that strobe the block latches the hit flags, the 3-bit amplitude codes and the current crossing number. Channels switched off in a programmable mask are dropped at the same moment.

A token then walks the latched hits in ascending channel order. Each holder of the token puts exactly one word onto the shared output. At most four words are granted per capture. Any hits beyond four are thrown away and raise a sticky overflow flag. This keeps later crossings from leaking words that carry the wrong time stamp. An output holding register keeps a formed word steady for as long as the FIFO reports full.

Top module: `hit_collector`

## Requirements
- R1: After reset, `word_valid_o` and `ovf_o` are 0, the crossing counter is 0, the capture phase is 0 and every mask bit is 0 (all channels enabled).
- R2: Mask bit = 1 disables a channel. A write with `mask_sel_i` = k loads channels 32k..32k+31, with channel 32k+j taken from `mask_data_i[j]`. A channel masked at the capture strobe produces no word.
- R3: Only channels whose hit flag is 1 at the capture strobe produce words. A capture with no unmasked hit produces no word.
- R4: The words of one capture leave in strictly ascending channel order, one word per granted channel. Each grant loads the output register on the next free cycle.
- R5: A strobe on `bco_i` advances a 2-bit phase that counts strobes modulo 4. Only a strobe seen in phase 0 captures, and the first strobe after reset is in phase 0. Hits present at strobes in phases 1 to 3 are ignored.
- R6: A 7-bit crossing counter advances by one on every strobe and wraps from 127 to 0. A word carries the counter value held just before its capture strobe, so the first capture after reset is stamped 0.
- R7: At most 4 words come from one capture. Further latched hits are discarded without a word, and `ovf_o` becomes 1 and stays 1 until reset.
- R8: A phase-0 strobe is skipped while hits of the previous capture have not yet been loaded into the output register. It produces no words, and it sets `ovf_o` if any unmasked hit was present on that strobe.
- R9: Word layout: bit 19 = 0, bits 18:12 = channel number, bits 11:5 = crossing stamp, bits 4:2 = amplitude code, bits 1:0 = 0.
- R10: A word transfers on a clock edge where `word_valid_o` = 1 and `fifo_full_i` = 0. While `fifo_full_i` = 1, `word_valid_o` stays 1 and `word_o` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bco_i | input | 1 | One-cycle beam-crossing strobe |
| hit_i | input | 128 | Per-channel discriminator hit flags |
| amp_i | input | 384 | 3-bit amplitude code per channel; channel c at bits 3c+2:3c |
| mask_we_i | input | 1 | Mask word write enable |
| mask_sel_i | input | 2 | Mask word select |
| mask_data_i | input | 32 | Mask word data, 1 = channel disabled |
| fifo_full_i | input | 1 | Downstream FIFO full |
| word_valid_o | output | 1 | Output word present |
| word_o | output | 20 | Formed hit word |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The hardest case to reach from the ports is the skipped capture. A new phase-0 strobe must arrive while the previous batch still has unloaded hits. The bench arranges this by holding `fifo_full_i` high through a whole four-strobe group after a three-hit capture, so that two hits are still waiting in the token chain when the next capture strobe arrives with fresh hits. A reset just before this scenario clears the sticky flag, so the rise of `ovf_o` can only come from the skip.

// File: rtl/hc_pkg.sv
package hc_pkg;
   localparam int TS_W  = 7;
   localparam int AMP_W = 3;
   localparam int RSV_W = 2;
endpackage

// File: rtl/hc_mask_bank.sv
module hc_mask_bank #(
   parameter int N_CH   = 128,
   parameter int WORD_W = 32,
   localparam int N_WORDS = N_CH / WORD_W,
   localparam int SEL_W   = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [SEL_W-1:0]  sel_i,
   input  logic [WORD_W-1:0] data_i,
   output logic [N_CH-1:0]   mask_o
);
   generate
      if (N_CH % WORD_W != 0) begin : g_bad_split
         $error("mask word width must divide channel count");
      end
      for (genvar w = 0; w < N_WORDS; w++) begin : g_word
         always_ff @(posedge clk) begin
            if (!rst_n)
               mask_o[w*WORD_W +: WORD_W] <= '0;
            else if (we_i && (int'(sel_i) == w))
               mask_o[w*WORD_W +: WORD_W] <= data_i;
         end
      end
   endgenerate
endmodule

// File: rtl/hc_phase_timer.sv
module hc_phase_timer #(
   parameter int PHASES = 4,
   parameter int TS_W   = 7,
   localparam int PH_W  = (PHASES > 1) ? $clog2(PHASES) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bco_i,
   output logic [TS_W-1:0] ts_o,
   output logic            cap_phase_o
);
   logic [PH_W-1:0] phase;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ts_o  <= '0;
         phase <= '0;
      end else if (bco_i) begin
         ts_o  <= ts_o + 1'b1;
         phase <= (int'(phase) == PHASES-1) ? '0 : phase + 1'b1;
      end
   end

   assign cap_phase_o = (phase == '0);

   p_ts_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      bco_i |=> ts_o == $past(ts_o) + 1'b1);
   p_ts_still_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !bco_i |=> $stable(ts_o));
endmodule

// File: rtl/hc_token_chain.sv
module hc_token_chain #(
   parameter int N_CH = 128,
   localparam int ID_W = $clog2(N_CH)
) (
   input  logic [N_CH-1:0] req_i,
   output logic [N_CH-1:0] grant_o,
   output logic [ID_W-1:0] idx_o,
   output logic            any_o
);
   always_comb begin
      logic tok;
      tok     = 1'b1;
      grant_o = '0;
      idx_o   = '0;
      for (int c = 0; c < N_CH; c++) begin
         grant_o[c] = tok & req_i[c];
         if (grant_o[c]) idx_o = ID_W'(c);
         tok = tok & ~req_i[c];
      end
      any_o = ~tok;
   end

   always_comb begin
      if (!$isunknown(req_i))
         p_token_single_r4: assert ($onehot0(grant_o));
   end
endmodule

// File: rtl/hit_collector.sv
module hit_collector #(
   parameter int N_CH    = 128,
   parameter int MASK_W  = 32,
   parameter int PHASES  = 4,
   parameter int LIMIT   = 4,
   localparam int ID_W   = $clog2(N_CH),
   localparam int SEL_W  = ((N_CH / MASK_W) > 1) ? $clog2(N_CH / MASK_W) : 1,
   localparam int WORD_W = 1 + ID_W + hc_pkg::TS_W + hc_pkg::AMP_W + hc_pkg::RSV_W,
   localparam int GNT_W  = $clog2(LIMIT + 1)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         bco_i,
   input  logic [N_CH-1:0]              hit_i,
   input  logic [N_CH*hc_pkg::AMP_W-1:0] amp_i,
   input  logic                         mask_we_i,
   input  logic [SEL_W-1:0]             mask_sel_i,
   input  logic [MASK_W-1:0]            mask_data_i,
   input  logic                         fifo_full_i,
   output logic                         word_valid_o,
   output logic [WORD_W-1:0]            word_o,
   output logic                         ovf_o
);
   import hc_pkg::*;

   localparam logic [GNT_W-1:0] LIMIT_C = GNT_W'(LIMIT);

   generate
      if ((1 << ID_W) != N_CH) begin : g_bad_count
         $error("channel count must be a power of two");
      end
      if (LIMIT < 1) begin : g_bad_limit
         $error("hit limit must be at least one");
      end
   endgenerate

   logic [N_CH-1:0]         mask;
   logic [TS_W-1:0]         ts_now;
   logic                    cap_phase;
   logic [N_CH-1:0]         pend;
   logic [N_CH*AMP_W-1:0]   amp_l;
   logic [TS_W-1:0]         ts_l;
   logic [GNT_W-1:0]        grants;
   logic [N_CH-1:0]         grant;
   logic [ID_W-1:0]         tok_idx;
   logic                    tok_any;
   logic                    cap_strobe;
   logic                    slot_free;

   hc_mask_bank #(.N_CH(N_CH), .WORD_W(MASK_W)) u_mask (
      .clk(clk), .rst_n(rst_n), .we_i(mask_we_i), .sel_i(mask_sel_i),
      .data_i(mask_data_i), .mask_o(mask));

   hc_phase_timer #(.PHASES(PHASES), .TS_W(TS_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .bco_i(bco_i), .ts_o(ts_now),
      .cap_phase_o(cap_phase));

   hc_token_chain #(.N_CH(N_CH)) u_chain (
      .req_i(pend), .grant_o(grant), .idx_o(tok_idx), .any_o(tok_any));

   assign cap_strobe = bco_i && cap_phase;
   assign slot_free  = !word_valid_o || !fifo_full_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend         <= '0;
         amp_l        <= '0;
         ts_l         <= '0;
         grants       <= '0;
         word_valid_o <= 1'b0;
         word_o       <= '0;
         ovf_o        <= 1'b0;
      end else begin
         if (word_valid_o && !fifo_full_i)
            word_valid_o <= 1'b0;
         if (!tok_any) begin
            if (cap_strobe) begin
               pend   <= hit_i & ~mask;
               amp_l  <= amp_i;
               ts_l   <= ts_now;
               grants <= '0;
            end
         end else if (grants == LIMIT_C) begin
            pend  <= '0;
            ovf_o <= 1'b1;
         end else if (slot_free) begin
            word_valid_o  <= 1'b1;
            word_o        <= {1'b0, tok_idx, ts_l,
                              amp_l[int'(tok_idx)*AMP_W +: AMP_W], {RSV_W{1'b0}}};
            pend[tok_idx] <= 1'b0;
            grants        <= grants + 1'b1;
         end
         if (cap_strobe && tok_any && |(hit_i & ~mask))
            ovf_o <= 1'b1;
      end
   end

   p_hold_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid_o && fifo_full_i |=> word_valid_o && $stable(word_o));
   p_word_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid_o |-> !word_o[WORD_W-1] && word_o[RSV_W-1:0] == '0);
   p_grant_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      grants <= LIMIT_C);
   p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |=> ovf_o);
   p_pend_shrinks_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tok_any |=> (pend & ~$past(pend)) == '0);
endmodule

// File: tb/hit_collector_test.sv
module hit_collector_test;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bco_i = 1'b0;
   logic [127:0] hit_i = '0;
   logic [383:0] amp_i = '0;
   logic         mask_we_i = 1'b0;
   logic [1:0]   mask_sel_i = '0;
   logic [31:0]  mask_data_i = '0;
   logic         fifo_full_i = 1'b0;
   logic         word_valid_o;
   logic [19:0]  word_o;
   logic         ovf_o;

   int n_chk = 0;
   int n_err = 0;
   logic [19:0] exp_q[$];
   logic [127:0] mask_m = '0;
   logic [6:0]   ts_m = '0;
   int           phase_m = 0;
   logic         ovf_m = 1'b0;
   logic         prev_hold = 1'b0;
   logic [19:0]  prev_word = '0;

   always #2 clk = ~clk;

   hit_collector uut (
      .clk(clk), .rst_n(rst_n), .bco_i(bco_i), .hit_i(hit_i), .amp_i(amp_i),
      .mask_we_i(mask_we_i), .mask_sel_i(mask_sel_i), .mask_data_i(mask_data_i),
      .fifo_full_i(fifo_full_i), .word_valid_o(word_valid_o), .word_o(word_o),
      .ovf_o(ovf_o));

   task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [2:0] amp_of(input int ch, input int seed);
      return 3'((ch * 5 + seed) % 8);
   endfunction

   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_hold)
            chk(word_valid_o && word_o == prev_word, "R10 held word", {12'd0, word_o},
                {12'd0, prev_word});
         if (word_valid_o && !fifo_full_i) begin
            if (exp_q.size() == 0)
               chk(1'b0, "R3 unexpected word", {12'd0, word_o}, 32'd0);
            else begin
               logic [19:0] e;
               e = exp_q.pop_front();
               chk(word_o == e, "R4 R9 word", {12'd0, word_o}, {12'd0, e});
            end
         end
         prev_hold = word_valid_o && fifo_full_i;
         prev_word = word_o;
      end else
         prev_hold = 1'b0;
   end

   task automatic strobe(input logic [127:0] h, input int seed, input int gap);
      logic busy;
      int   cnt;
      @(posedge clk); #1;
      hit_i = h;
      for (int c = 0; c < 128; c++) amp_i[c*3 +: 3] = amp_of(c, seed);
      bco_i = 1'b1;
      busy = exp_q.size() > int'(word_valid_o);
      if (phase_m == 0) begin
         if (!busy) begin
            cnt = 0;
            for (int c = 0; c < 128; c++)
               if (h[c] && !mask_m[c]) begin
                  if (cnt < 4) exp_q.push_back({1'b0, 7'(c), ts_m, amp_of(c, seed), 2'b00});
                  else ovf_m = 1'b1;
                  cnt++;
               end
         end else if ((h & ~mask_m) != '0)
            ovf_m = 1'b1;
      end
      ts_m = ts_m + 1'b1;
      phase_m = (phase_m + 1) % 4;
      @(posedge clk); #1;
      bco_i = 1'b0;
      hit_i = '0;
      repeat (gap) @(posedge clk);
   endtask

   task automatic group(input logic [127:0] h, input int seed,
                        input logic [127:0] late);
      strobe(h, seed, 8);
      strobe(late, seed + 1, 8);
      strobe(late, seed + 2, 8);
      strobe(late, seed + 3, 8);
   endtask

   task automatic write_mask(input logic [1:0] sel, input logic [31:0] d);
      @(posedge clk); #1;
      mask_we_i = 1'b1; mask_sel_i = sel; mask_data_i = d;
      mask_m[sel*32 +: 32] = d;
      @(posedge clk); #1;
      mask_we_i = 1'b0;
   endtask

   task automatic do_reset();
      @(posedge clk); #1;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      exp_q.delete(); mask_m = '0; ts_m = '0; phase_m = 0; ovf_m = 1'b0;
      chk(!word_valid_o, "R1 valid after reset", 32'(word_valid_o), 32'd0);
      chk(!ovf_o, "R1 overflow after reset", 32'(ovf_o), 32'd0);
      rst_n = 1'b1;
   endtask

   task automatic drained(input string tag);
      repeat (4) @(posedge clk);
      chk(exp_q.size() == 0, tag, 32'(exp_q.size()), 32'd0);
      chk(ovf_o == ovf_m, tag, 32'(ovf_o), 32'(ovf_m));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [127:0] h;
      do_reset();
      // R3 R6: single hit, first capture stamped 0
      h = '0; h[5] = 1'b1;
      group(h, 1, '0);
      drained("R3 single hit drained");
      // R4: ascending order including the edge channels
      h = '0; h[127] = 1'b1; h[0] = 1'b1; h[64] = 1'b1;
      group(h, 2, '0);
      drained("R4 edge channels drained");
      // R2: masked channels produce nothing
      write_mask(2'd1, 32'h0000_00F0);
      h = '0; h[36] = 1'b1; h[37] = 1'b1; h[40] = 1'b1;
      group(h, 3, '0);
      drained("R2 mask applied");
      write_mask(2'd1, 32'h0);
      group(h, 4, '0);
      drained("R2 mask cleared");
      // R5: hits on non-capture strobes are ignored
      h = '0; h[9] = 1'b1;
      group('0, 5, h);
      drained("R5 late hits ignored");
      // R10: FIFO full holds the word
      h = '0; h[2] = 1'b1; h[3] = 1'b1;
      @(posedge clk); #1; fifo_full_i = 1'b1;
      strobe(h, 6, 12);
      @(posedge clk); #1; fifo_full_i = 1'b0;
      strobe('0, 7, 8); strobe('0, 8, 8); strobe('0, 9, 8);
      drained("R10 full stall drained");
      // R6: time stamp wrap
      for (int k = 0; k < 132; k++) strobe('0, 0, 1);
      h = '0; h[77] = 1'b1;
      group(h, 10, '0);
      drained("R6 wrapped stamp");
      // R7: more than four hits
      chk(!ovf_o, "R7 overflow clear before", 32'(ovf_o), 32'd0);
      h = '0; h[1] = 1'b1; h[20] = 1'b1; h[30] = 1'b1; h[50] = 1'b1; h[90] = 1'b1;
      h[100] = 1'b1;
      group(h, 11, '0);
      drained("R7 limit four");
      chk(ovf_o, "R7 overflow set", 32'(ovf_o), 32'd1);
      // R8: capture skipped while previous batch still pending
      do_reset();
      chk(!ovf_o, "R1 overflow cleared", 32'(ovf_o), 32'd0);
      h = '0; h[11] = 1'b1; h[12] = 1'b1; h[13] = 1'b1;
      @(posedge clk); #1; fifo_full_i = 1'b1;
      group(h, 12, '0);
      h = '0; h[60] = 1'b1; h[61] = 1'b1;
      strobe(h, 13, 4);
      @(posedge clk); #1; fifo_full_i = 1'b0;
      strobe('0, 14, 8); strobe('0, 15, 8); strobe('0, 16, 8);
      drained("R8 skipped capture");
      chk(ovf_o, "R8 overflow set by skip", 32'(ovf_o), 32'd1);
      repeat (4) @(posedge clk);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule